// File: doc/BRIEF.md
# Serial ADC host controller

The block runs the host side of a multiplexed serial analog-to-digital converter. It drives the converter's active-low chip select, serial clock and serial data input, and it samples the converter's serial data output. A request carries a 4-bit channel number and a mode bit. The controller first screens the channel. Codes that would put the converter into its digital test mode are refused. For a legal code it shifts the address out and then waits for the conversion. Last, it shifts the 8-bit result in and reports it with a one-cycle valid strobe and the channel it belongs to.

End of conversion is found in one of two ways. In fixed-wait mode the serial clock is parked low and chip select is held low for 64 serial-clock periods. In polling mode the serial clock keeps running and the controller watches the data line: it stays low during conversion and goes high when the result's MSB appears. A polling frame that sees no high level within 80 periods is aborted with a timeout flag. The serial clock is derived from the system clock by a run-time divider. Every read fetches one fresh sample.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset, and whenever no frame is open, cs_no is 1, sclk_o is 0, ready_o is 1 and valid_o, err_o and timeout_o are 0.
- R2: A frame opens with cs_no falling and di_o holding chan bit 3. The address goes out MSB first, one bit per serial-clock period. di_o changes only on falling sclk_o edges or when the frame opens, so the converter samples bits 3..0 on rising edges 1..4.
- R3: A request with chan_i >= 12 opens no frame. It raises err_o for one cycle, in the cycle after the request, and ready_o stays 1.
- R4: The address phase lasts 8 sclk_o periods. In fixed-wait mode (poll_i = 0), sclk_o then stays low with cs_no low. The first read rising edge comes exactly 129 × (div_i + 1) system clocks after the 8th falling edge, which is 64 full periods plus one half period.
- R5: In fixed-wait mode the result is sampled on 8 rising edges, MSB first. On the 8th falling edge cs_no rises and valid_o pulses for one cycle with data_o and chan_o.
- R6: In polling mode (poll_i = 1), sclk_o keeps toggling after the address phase. The first rising-edge sample with do_i = 1 is taken as the MSB (value 1), and 7 more bits follow on later rising edges.
- R7: In polling mode, if 80 rising edges after the address phase all sample do_i = 0, the frame ends on the next falling edge. At that point cs_no rises and timeout_o pulses for one cycle, and valid_o is not raised.
- R8: ready_o goes low in the cycle after an accepted request and stays low until the report. A request made while ready_o is low is ignored.
- R9: Each sclk_o half period lasts div_i + 1 system clocks, so a full period lasts 2 × (div_i + 1) system clocks.
- R10: Each accepted request produces exactly one frame and exactly one report, and every rise of cs_no comes with valid_o or timeout_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Conversion request, taken when ready_o is 1 |
| chan_i | input | 4 | Requested channel number |
| poll_i | input | 1 | 1 = poll data line for end of conversion, 0 = fixed wait |
| div_i | input | 8 | Serial clock half period minus one, in system clocks |
| do_i | input | 1 | Converter serial data output |
| ready_o | output | 1 | Controller idle and accepting requests |
| cs_no | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to converter |
| di_o | output | 1 | Serial address to converter |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | 8 | Conversion result |
| chan_o | output | 4 | Channel of the reported result |
| err_o | output | 1 | One-cycle pulse: request refused (test-mode code) |
| timeout_o | output | 1 | One-cycle pulse: polling gave up |

## Verification
Some rules are checked on every cycle. The serial clock is low whenever chip select is high. The address line moves only on falling clock edges or at frame start. No frame ever opens for a code of 12 or more. ready_o is low while a frame is open. Each frame closes with a valid or timeout pulse. Other behaviour needs the bench's converter model and its scenarios: the exact length of the quiet fixed-mode wait, the recovered data and channel, the running clock during polling, the timeout under a slow conversion, the ignored busy request, and the clock period at several divider settings.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_POLL,
    ST_READ
  } st_e;
endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             toggle_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             tick_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);
  assign rise_o = tick_o && toggle_i && !sclk_o;
  assign fall_o = tick_o && toggle_i && sclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
      if (tick_o && toggle_i) sclk_o <= ~sclk_o;
    end
  end
endmodule

// File: rtl/adc_chan_gate.sv
module adc_chan_gate #(
  parameter int ADDR_W    = 4,
  parameter int TEST_BASE = 12
) (
  input  logic [ADDR_W-1:0] chan_i,
  output logic              legal_o
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(TEST_BASE);
  assign legal_o = chan_i < BASE;
endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
  import adc_host_pkg::*;
#(
  parameter int ADDR_W          = 4,
  parameter int RES_W           = 8,
  parameter int WAIT_PERIODS    = 64,
  parameter int TIMEOUT_PERIODS = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] chan_i,
  input  logic              legal_i,
  input  logic              poll_i,
  input  logic              tick_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              do_i,
  output logic              run_o,
  output logic              toggle_o,
  output logic              ready_o,
  output logic              cs_no,
  output logic              di_o,
  output logic              valid_o,
  output logic [RES_W-1:0]  data_o,
  output logic [ADDR_W-1:0] chan_o,
  output logic              err_o,
  output logic              timeout_o
);
  localparam int ADDR_FALLS = 2 * ADDR_W;
  localparam int WAIT_TICKS = 2 * WAIT_PERIODS;
  localparam int CNT_MAX    = (WAIT_TICKS > TIMEOUT_PERIODS + 1) ? WAIT_TICKS : TIMEOUT_PERIODS + 1;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int BIT_W      = $clog2(RES_W + 1);

  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  nbits_q;
  logic [ADDR_W-1:0] sh_out_q;
  logic [RES_W-1:0]  sh_in_q;
  logic              poll_q;

  assign run_o    = (st_q != ST_IDLE);
  assign toggle_o = (st_q == ST_ADDR) || (st_q == ST_POLL) || (st_q == ST_READ);
  assign ready_o  = (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      nbits_q   <= '0;
      sh_out_q  <= '0;
      sh_in_q   <= '0;
      poll_q    <= 1'b0;
      cs_no     <= 1'b1;
      di_o      <= 1'b0;
      valid_o   <= 1'b0;
      data_o    <= '0;
      chan_o    <= '0;
      err_o     <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      err_o     <= 1'b0;
      timeout_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          if (!legal_i) begin
            err_o <= 1'b1;
          end else begin
            cs_no    <= 1'b0;
            di_o     <= chan_i[ADDR_W-1];
            sh_out_q <= {chan_i[ADDR_W-2:0], 1'b0};
            chan_o   <= chan_i;
            poll_q   <= poll_i;
            cnt_q    <= '0;
            st_q     <= ST_ADDR;
          end
        end
        ST_ADDR: if (fall_i) begin
          di_o     <= sh_out_q[ADDR_W-1];
          sh_out_q <= sh_out_q << 1;
          cnt_q    <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ADDR_FALLS - 1)) begin
            cnt_q <= '0;
            st_q  <= poll_q ? ST_POLL : ST_WAIT;
          end
        end
        ST_WAIT: if (tick_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(WAIT_TICKS - 1)) begin
            cnt_q   <= '0;
            nbits_q <= '0;
            st_q    <= ST_READ;
          end
        end
        ST_POLL: begin
          if (rise_i) begin
            if (do_i) begin
              sh_in_q <= {{(RES_W-1){1'b0}}, 1'b1};  // MSB seen
              nbits_q <= BIT_W'(1);
              st_q    <= ST_READ;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end else if (fall_i && cnt_q == CNT_W'(TIMEOUT_PERIODS)) begin
            timeout_o <= 1'b1;
            cs_no     <= 1'b1;
            st_q      <= ST_IDLE;
          end
        end
        ST_READ: begin
          if (rise_i) begin
            sh_in_q <= {sh_in_q[RES_W-2:0], do_i};
            nbits_q <= nbits_q + 1'b1;
          end else if (fall_i && nbits_q == BIT_W'(RES_W)) begin
            valid_o <= 1'b1;
            data_o  <= sh_in_q;
            cs_no   <= 1'b1;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl #(
  parameter int ADDR_W          = 4,
  parameter int RES_W           = 8,
  parameter int DIV_W           = 8,
  parameter int TEST_BASE       = 12,
  parameter int WAIT_PERIODS    = 64,
  parameter int TIMEOUT_PERIODS = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] chan_i,
  input  logic              poll_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              do_i,
  output logic              ready_o,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              di_o,
  output logic              valid_o,
  output logic [RES_W-1:0]  data_o,
  output logic [ADDR_W-1:0] chan_o,
  output logic              err_o,
  output logic              timeout_o
);
  logic legal, run, toggle, tick, rise, fall;

  adc_chan_gate #(.ADDR_W(ADDR_W), .TEST_BASE(TEST_BASE)) u_gate (
    .chan_i (chan_i),
    .legal_o(legal)
  );

  adc_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .toggle_i(toggle),
    .div_i   (div_i),
    .sclk_o  (sclk_o),
    .tick_o  (tick),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  adc_host_seq #(
    .ADDR_W(ADDR_W), .RES_W(RES_W),
    .WAIT_PERIODS(WAIT_PERIODS), .TIMEOUT_PERIODS(TIMEOUT_PERIODS)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .chan_i   (chan_i),
    .legal_i  (legal),
    .poll_i   (poll_i),
    .tick_i   (tick),
    .rise_i   (rise),
    .fall_i   (fall),
    .do_i     (do_i),
    .run_o    (run),
    .toggle_o (toggle),
    .ready_o  (ready_o),
    .cs_no    (cs_no),
    .di_o     (di_o),
    .valid_o  (valid_o),
    .data_o   (data_o),
    .chan_o   (chan_o),
    .err_o    (err_o),
    .timeout_o(timeout_o)
  );
endmodule

// File: rtl/adc_host_ctrl_chk.sv
module adc_host_ctrl_chk #(
  parameter int ADDR_W    = 4,
  parameter int TEST_BASE = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [ADDR_W-1:0] chan_i,
  input logic              ready_o,
  input logic              cs_no,
  input logic              sclk_o,
  input logic              di_o,
  input logic              valid_o,
  input logic              err_o,
  input logic              timeout_o
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(TEST_BASE);

  p_idle_clock_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  p_di_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$fell(sclk_o) && !$fell(cs_no)) |-> $stable(di_o));

  p_no_test_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> ($past(chan_i) < BASE && $past(req_i)));

  p_err_no_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cs_no && ready_o));

  p_busy_not_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !ready_o);

  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_frame_reports_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (valid_o || timeout_o));
endmodule

bind adc_host_ctrl adc_host_ctrl_chk u_chk (.*);

// File: tb/adc_host_ctrl_bench.sv
`timescale 1ns/1ps
module adc_host_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, poll = 1'b0;
  logic [3:0] chan = '0;
  logic [7:0] div = 8'd1;
  logic       do_l = 1'b0;
  logic       rdy, cs_n, sclk, di, vld, err, tmo;
  logic [7:0] data;
  logic [3:0] chan_out;

  always #2.5 clk = ~clk;

  adc_host_ctrl u_adc_host_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .chan_i(chan), .poll_i(poll),
    .div_i(div), .do_i(do_l), .ready_o(rdy), .cs_no(cs_n), .sclk_o(sclk),
    .di_o(di), .valid_o(vld), .data_o(data), .chan_o(chan_out),
    .err_o(err), .timeout_o(tmo)
  );

  typedef struct {int kind; logic [7:0] d; logic [3:0] ch;} exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0, frames = 0;
  bit done = 0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] res_of(logic [3:0] c);
    return 8'h81 + c * 8'd19;
  endfunction

  // converter model
  int conv_lat = 100;
  logic m_sclk_prev = 1'b0;
  int m_rises = 0, m_falls = 0, m_cnt = 0, m_idx = 0, m_gap = -1, m_conv_rises = 0, m_period = 0;
  bit m_conv = 0, m_pres = 0, m_seen = 0;
  logic [3:0] m_addr = '0;
  logic [7:0] m_res = '0;
  realtime t_conv = 0, t_prev = 0, t_last = 0;

  always @(negedge clk or posedge sclk or negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      m_rises = 0; m_falls = 0; m_conv = 0; m_pres = 0; m_seen = 0; do_l = 1'b0;
    end else if (sclk !== m_sclk_prev) begin
      if (sclk) begin
        if (m_rises < 4) m_addr = {m_addr[2:0], di};
        m_rises++;
        if (m_conv) m_conv_rises++;
        if (m_pres) m_seen = 1;
        if (m_falls == 8 && m_gap < 0) m_gap = int'(($realtime - t_conv) / 5.0);
        t_prev = t_last; t_last = $realtime;
        m_period = int'((t_last - t_prev) / 5.0);
      end else begin
        m_falls++;
        if (m_falls == 8) begin
          m_conv = 1; m_cnt = 0; do_l = 1'b0; t_conv = $realtime; m_gap = -1; m_conv_rises = 0;
        end else if (m_pres && m_seen) begin
          m_idx--;
          do_l = (m_idx >= 0) ? m_res[m_idx] : 1'b0;
          m_seen = 0;
        end
      end
    end else if (m_conv) begin
      m_cnt++;
      if (m_cnt >= conv_lat) begin
        m_conv = 0; m_pres = 1; m_idx = 7; m_res = res_of(m_addr); do_l = m_res[7]; m_seen = 0;
      end
    end
    m_sclk_prev = sclk;
  end

  // monitor / scoreboard
  logic cs_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_prev && !cs_n) frames++;
      cs_prev = cs_n;
      if (vld || err || tmo) begin
        if (exp_q.size() == 0) begin
          check("R10 unexpected report", 1, 0);
        end else begin
          exp_t e;
          int kind;
          e = exp_q.pop_front();
          kind = vld ? 0 : (err ? 1 : 2);
          check("R10 report kind", kind, e.kind);
          if (vld) begin
            check("R5 result data", data, e.d);
            check("R5 result channel", chan_out, e.ch);
            check("R2 address seen by converter", m_addr, e.ch);
          end
          if (err) check("R3 no frame on refusal", cs_n, 1);
          if (tmo) begin
            check("R7 chip select released", cs_n, 1);
            check("R7 no valid on timeout", vld, 0);
          end
        end
      end
    end
  end

  task automatic run_req(logic [3:0] ch, bit pm, int lat);
    int kind, fr0;
    kind = (ch >= 12) ? 1 : ((pm && lat > 80 * 2 * (div + 1)) ? 2 : 0);
    conv_lat = lat;
    @(negedge clk);
    while (!rdy) @(negedge clk);
    fr0 = frames;
    chan = ch; poll = pm; req = 1'b1;
    exp_q.push_back('{kind, res_of(ch), ch});
    @(negedge clk);
    req = 1'b0;
    if (kind == 1) check("R3 ready stays high", rdy, 1);
    else check("R8 ready low after accept", rdy, 0);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R10 one frame per request", frames - fr0, (kind == 1) ? 0 : 1);
    check("R1 idle lines", {cs_n, sclk, rdy}, 3'b101);
    if (kind == 0 && !pm) begin
      check("R4 quiet wait length", m_gap, 129 * (div + 1));
      check("R4 no clock during conversion", m_conv_rises, 0);
    end
    if (kind == 0 && pm) check("R6 clock runs while polling", m_conv_rises > 0, 1);
    if (kind != 1) check("R9 clock period", m_period, 2 * (div + 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset lines", {cs_n, sclk, rdy, vld, err, tmo}, 6'b101000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", {cs_n, sclk, rdy, vld, err, tmo}, 6'b101000);

    div = 8'd1;
    run_req(4'd3, 1'b0, 100);
    run_req(4'd10, 1'b0, 100);
    run_req(4'd11, 1'b0, 100);
    div = 8'd0;
    run_req(4'd5, 1'b0, 100);
    div = 8'd2;
    run_req(4'd0, 1'b0, 100);
    // R3 test-mode codes
    div = 8'd1;
    run_req(4'd12, 1'b0, 100);
    run_req(4'd15, 1'b1, 100);
    // R6 polling with MSB = 1 results
    run_req(4'd4, 1'b1, 100);
    div = 8'd0;
    run_req(4'd1, 1'b1, 60);
    // R7 slow conversion in polling mode
    div = 8'd1;
    run_req(4'd6, 1'b1, 1000);

    // R8 request while busy is ignored
    begin
      int fr0;
      conv_lat = 100;
      @(negedge clk);
      fr0 = frames;
      chan = 4'd2; poll = 1'b0; req = 1'b1;
      exp_q.push_back('{0, res_of(4'd2), 4'd2});
      @(negedge clk);
      req = 1'b0;
      repeat (10) @(negedge clk);
      chan = 4'd9; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      check("R8 still busy", rdy, 0);
      while (exp_q.size() != 0) @(negedge clk);
      repeat (20) @(negedge clk);
      check("R8 busy request ignored", frames - fr0, 1);
      check("R8 channel of kept request", chan_out, 2);
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule